// File: doc/BRIEF.md
# Four-Bit Eight-Function Ripple ALU

This block is a purely combinational arithmetic logic unit for two 4-bit operands. A 3-bit operation code picks one of four arithmetic functions (increment, decrement, add, subtract) or one of four bitwise functions (AND, OR, XOR, XNOR). It produces a 4-bit result and a carry-out that settle within the same cycle the operands and code are applied.

Every bit position is built from three parts. An operand selector forms the adder's second input from the B bit, its complement, a constant 0 or a constant 1. A full adder takes that input and the carry from the stage below. A result selector then passes either the adder sum or one of the four bitwise results. The carry travels from bit 0 up to bit 3. The top bit of the code chooses between the arithmetic and the bitwise group. The two low bits steer both selectors and set the carry into bit 0.

Top module: `alu4_ripple`

## Requirements
- R1: With op_sel = 3'b000 (increment), result = (opa + 1) mod 16 and carry_out = 1 only when opa = 4'hF.
- R2: With op_sel = 3'b001 (decrement), result = (opa - 1) mod 16 and carry_out = 0 only when opa = 4'h0 (the adder adds all-ones with a carry-in of 0).
- R3: With op_sel = 3'b010 (add), {carry_out, result} = opa + opb taken as a 5-bit sum.
- R4: With op_sel = 3'b011 (subtract), result = (opa - opb) mod 16, computed as opa plus inverted opb plus 1, and carry_out = 1 exactly when opa >= opb (no borrow).
- R5: With op_sel = 3'b100, result = opa AND opb, bit by bit.
- R6: With op_sel = 3'b101, result = opa OR opb, bit by bit.
- R7: With op_sel = 3'b110, result = opa XOR opb, bit by bit.
- R8: With op_sel = 3'b111, result = opa XNOR opb, bit by bit.
- R9: Whenever op_sel[2] = 1, carry_out = 0.
- R10: Under increment and decrement, opb has no effect on result or carry_out.
- R11: A carry born at bit 0 reaches bit 3 and the carry-out. Add with opa = 4'b0001 and opb = 4'b1111 gives result 0 and carry_out 1. Increment with opa = 4'b1111 gives the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| op_sel | input | 3 | Operation code; bit 2 picks the bitwise group |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Carry from the top stage; 0 for bitwise operations |

## Verification
Two things happen at once in this block: the result wraps around to a small value, and the carry-out is raised. Both come from the same ripple through all four stages. The bench provokes this with the full-ripple patterns and with an exhaustive sweep of every operand pair under every code. It judges the result and the carry-out together against a 5-bit reference, so a carry that is lost or stuck shows up as a mismatch in the pair.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    typedef enum logic [2:0] {
        OP_INC  = 3'b000,
        OP_DEC  = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_XNOR = 3'b111
    } alu_op_e;

    // Codes for the two low select bits, shared by both per-bit selectors.
    localparam logic [1:0] PICK_ZERO = 2'b00;
    localparam logic [1:0] PICK_ONE  = 2'b01;
    localparam logic [1:0] PICK_B    = 2'b10;
    localparam logic [1:0] PICK_NB   = 2'b11;
endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
    import alu4_pkg::*;
(
    input  logic       b_bit,
    input  logic [1:0] pick,
    output logic       addend_d
);
    always_comb begin
        unique case (pick)
            PICK_ZERO: addend_d = 1'b0;
            PICK_ONE:  addend_d = 1'b1;
            PICK_B:    addend_d = b_bit;
            default:   addend_d = ~b_bit;
        endcase
    end
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic sum_d,
    output logic c_out
);
    always_comb begin
        sum_d = x_in ^ y_in ^ c_in;
        c_out = (x_in & y_in) | (y_in & c_in) | (c_in & x_in);
    end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux (
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       sum_bit,
    input  logic       bitwise,
    input  logic [1:0] pick,
    output logic       out_d
);
    logic logic_d;

    always_comb begin
        unique case (pick)
            2'b00:   logic_d = a_bit & b_bit;
            2'b01:   logic_d = a_bit | b_bit;
            2'b10:   logic_d = a_bit ^ b_bit;
            default: logic_d = ~(a_bit ^ b_bit);
        endcase
        out_d = bitwise ? logic_d : sum_bit;
    end
endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int SUMW = WIDTH + 1;

    logic [WIDTH:0]   carry_chain;
    logic [WIDTH-1:0] addend_d;
    logic [WIDTH-1:0] sum_d;
    logic             bitwise;

    assign bitwise        = op_sel[2];
    // Increment and subtract need a carry-in of 1.
    assign carry_chain[0] = ~(op_sel[1] ^ op_sel[0]);

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_operand_mux u_in (
            .b_bit    (opb[i]),
            .pick     (op_sel[1:0]),
            .addend_d (addend_d[i])
        );
        alu_full_adder u_fa (
            .x_in  (opa[i]),
            .y_in  (addend_d[i]),
            .c_in  (carry_chain[i]),
            .sum_d (sum_d[i]),
            .c_out (carry_chain[i+1])
        );
        alu_result_mux u_out (
            .a_bit   (opa[i]),
            .b_bit   (opb[i]),
            .sum_bit (sum_d[i]),
            .bitwise (bitwise),
            .pick    (op_sel[1:0]),
            .out_d   (result[i])
        );
    end

    assign carry_out = bitwise ? 1'b0 : carry_chain[WIDTH];

    // Checks against a plain-arithmetic reference
    logic [SUMW-1:0] ref_d;
    always_comb begin
        ref_d = '0;
        if (!$isunknown({opa, opb, op_sel})) begin
            unique case (alu_op_e'(op_sel))
                OP_INC: begin
                    ref_d = {1'b0, opa} + SUMW'(1);
                    p_inc_r1: assert ({carry_out, result} == ref_d);
                end
                OP_DEC: begin
                    ref_d = {1'b0, opa} + {1'b0, {WIDTH{1'b1}}};
                    p_dec_r2: assert ({carry_out, result} == ref_d);
                end
                OP_ADD: begin
                    ref_d = {1'b0, opa} + {1'b0, opb};
                    p_add_r3: assert ({carry_out, result} == ref_d);
                end
                OP_SUB: begin
                    ref_d = {1'b0, opa} + {1'b0, ~opb} + SUMW'(1);
                    p_sub_r4: assert ({carry_out, result} == ref_d);
                    p_noborrow_r4: assert (carry_out == (opa >= opb));
                end
                default: begin
                    p_logic_no_carry_r9: assert (carry_out == 1'b0);
                end
            endcase
        end
    end
endmodule

// File: tb/alu4_ripple_test.sv
module alu4_ripple_test;
    logic       clk = 1'b0;
    logic [3:0] opa = 4'h0;
    logic [3:0] opb = 4'h0;
    logic [2:0] op_sel = 3'b000;
    logic [3:0] result;
    logic       carry_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    alu4_ripple uut (
        .opa       (opa),
        .opb       (opb),
        .op_sel    (op_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic logic [4:0] model(input logic [2:0] op,
                                         input logic [3:0] a,
                                         input logic [3:0] b);
        case (op)
            3'b000:  return {1'b0, a} + 5'd1;
            3'b001:  return (a == 4'h0) ? {1'b0, 4'hF} : {1'b1, a - 4'd1};
            3'b010:  return {1'b0, a} + {1'b0, b};
            3'b011:  return {(a >= b), a - b};
            3'b100:  return {1'b0, a & b};
            3'b101:  return {1'b0, a | b};
            3'b110:  return {1'b0, a ^ b};
            default: return {1'b0, ~(a ^ b)};
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110:  return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s op=%b a=%h b=%h got=%h expected=%h", req, op_sel, opa, opb, got, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        op_sel = op; opa = a; opb = b;
        @(negedge clk);
    endtask

    task automatic t_first_vector;
        apply(3'b000, 4'h0, 4'h0);
        check("R1", {carry_out, result}, 5'h01);
    endtask

    task automatic t_sweep(input logic [2:0] op);
        for (int i = 0; i < 256; i++) begin
            apply(op, i[7:4], i[3:0]);
            check(req_of(op), {carry_out, result}, model(op, i[7:4], i[3:0]));
            if (op[2]) check("R9", {4'h0, carry_out}, 5'h00);
        end
    endtask

    task automatic t_b_ignored;
        for (int op = 0; op < 2; op++) begin
            logic [4:0] base;
            apply(op[2:0], 4'h6, 4'h0);
            base = {carry_out, result};
            for (int b = 1; b < 16; b++) begin
                apply(op[2:0], 4'h6, b[3:0]);
                check("R10", {carry_out, result}, base);
            end
        end
    endtask

    task automatic t_full_ripple;
        apply(3'b010, 4'b0001, 4'b1111);
        check("R11", {carry_out, result}, 5'b10000);
        apply(3'b000, 4'b1111, 4'b0101);
        check("R11", {carry_out, result}, 5'b10000);
        apply(3'b011, 4'b1000, 4'b1111);
        check("R4", {carry_out, result}, 5'b01001);
        apply(3'b001, 4'b0000, 4'b1010);
        check("R2", {carry_out, result}, 5'b01111);
    endtask

    initial begin
        t_first_vector();
        for (int op = 0; op < 8; op++) t_sweep(op[2:0]);
        t_b_ignored();
        t_full_ripple();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule